// File: doc/BRIEF.md
# Framebuffer Scanout Fetch Engine

The block reads one frame of pixel bytes at a time out of a linear framebuffer and hands them, in address order, to a pixel unpacker. Software programs where the frame starts, how many bytes each line carries, how many lines the frame has (held as the index of the last line) and the byte distance from one line start to the next. It then sets a run bit. From there the engine walks the frame line by line and issues burst read requests toward memory. It accepts up to a set number of those bursts in flight. Each returned byte goes into a local FIFO, and the FIFO feeds a valid/ready byte stream.

The engine reserves FIFO room before it sends each request, so returned data always has a place to land. A stalled consumer therefore pauses the fetching and loses nothing. When the last byte of a frame has come back from memory, a sticky interrupt flag sets, and software clears it through a register write. The start address is read once at each frame start. Writing a new address during a frame changes nothing until the next frame, so the interrupt tells software that the new address is now the one in use. While the frame runs, the while the run bit stays set, frames follow one another with no software action. An underrun output flags every cycle in which the unpacker wants a byte during a frame and none is waiting.

Top module: `fb_scan_fetch`

## Requirements
- R1: After reset, px_valid, rd_req_valid, frame_irq and underrun are all 0, and no request is issued until the run bit is set.
- R2: The byte stream carries, in order, the bytes at addresses base + l*pitch + k, for l from 0 to the last-line index and k from 0 to line length minus 1. Register indices: 0 start address, 1 line length in bytes, 2 last-line index (line count minus one), 3 line pitch, 4 control (bit 0 = run), 5 interrupt clear (bit 0).
- R3: Every request asks for min(16, bytes left in the line) beats of one byte each, starting where the previous burst of that line ended. No burst reaches past the line length, so a line shorter than 16 bytes takes one short burst.
- R4: No more than MAX_OUT bursts (default 4) are in flight at once, a burst counting from its accepted request to its response beat marked last, and with a slow memory that limit is reached.
- R5: With px_ready held low, the engine issues only as many bytes of requests as fit in the FIFO (default 64 bytes). Once the consumer resumes, the frame arrives complete and in order.
- R6: A start address written during a frame takes effect at the next frame start; the current frame finishes from the old address.
- R7: frame_irq sets after the last response byte of a frame arrives. It stays set until a write to index 5 with bit 0 = 1, and it reads 0 right after that write.
- R8: Writing run = 0 stops new requests. The unfinished frame is dropped without raising frame_irq, and setting run again starts a fresh frame at the start address.
- R9: underrun is 1 exactly when a frame is in progress, px_ready is 1 and no byte is available; it is 0 while stalled or idle.
- R10: With run held at 1, a new frame starts automatically after each completed frame and repeats the same byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the first beat |
| rd_req_beats | output | BEAT_W | Beats (bytes) in the burst, 1..MAX_BURST |
| rd_rsp_valid | input | 1 | Response byte valid |
| rd_rsp_data | input | 8 | Response byte |
| rd_rsp_last | input | 1 | Final beat of a burst |
| px_valid | output | 1 | Byte available to the unpacker |
| px_ready | input | 1 | Unpacker takes a byte |
| px_data | output | 8 | Byte to the unpacker |
| frame_irq | output | 1 | Sticky end-of-frame flag |
| underrun | output | 1 | Unpacker starved during a frame |

## Verification
A register write takes effect on the clock edge that captures it. The clear is therefore checked right after the write task returns, and a new start address is checked against the next frame's bytes, not against any fixed cycle. A request is recorded half a cycle before the edge that accepts it. A response byte enters the FIFO on its edge and shows on px_valid one cycle later, so the bench compares whole collected byte sequences and does not count latency. frame_irq rises on the second edge after the last response beat, and underrun is combinational from the FIFO state and px_ready. The bench waits for the flag within a bounded window and samples underrun on falling edges, well inside a known latency gap or a long idle period.

// File: rtl/fsf_pkg.sv
`timescale 1ns/1ps
package fsf_pkg;
   // Register indices decoded by the write port
   typedef enum logic [2:0] {
      REG_BASE  = 3'd0,
      REG_LEN   = 3'd1,
      REG_LAST  = 3'd2,
      REG_PITCH = 3'd3,
      REG_CTRL  = 3'd4,
      REG_ICLR  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/fsf_regs.sv
`timescale 1ns/1ps
module fsf_regs
   import fsf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              frame_done,
   output logic [ADDR_W-1:0] base,
   output logic [LEN_W-1:0]  line_len,
   output logic [LINE_W-1:0] last_line,
   output logic [ADDR_W-1:0] pitch,
   output logic              run,
   output logic              irq
);
   generate
      if (ADDR_W > 32 || LEN_W > 32 || LINE_W > 32) begin : g_bad_width
         $error("fsf_regs: register fields wider than the write bus");
      end
   endgenerate

   logic clr_hit;
   logic unused_wdata;
   assign clr_hit      = wr_en && (wr_addr == REG_ICLR) && wr_data[0];
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base      <= '0;
         line_len  <= '0;
         last_line <= '0;
         pitch     <= '0;
         run       <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_BASE:  base      <= wr_data[ADDR_W-1:0];
            REG_LEN:   line_len  <= wr_data[LEN_W-1:0];
            REG_LAST:  last_line <= wr_data[LINE_W-1:0];
            REG_PITCH: pitch     <= wr_data[ADDR_W-1:0];
            REG_CTRL:  run       <= wr_data[0];
            default: ;
         endcase
      end
   end

   // Completion wins over a clear arriving in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)          irq <= 1'b0;
      else if (frame_done) irq <= 1'b1;
      else if (clr_hit)    irq <= 1'b0;
   end

   p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> irq);
   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_hit) |=> irq);
endmodule

// File: rtl/fsf_fifo.sv
`timescale 1ns/1ps
module fsf_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fsf_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/fsf_fetch_gen.sv
`timescale 1ns/1ps
module fsf_fetch_gen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINE_W     = 12,
   parameter int MAX_BURST  = 16,
   parameter int MAX_OUT    = 4,
   parameter int FIFO_DEPTH = 64,
   localparam int BW  = $clog2(MAX_BURST + 1),
   localparam int OW  = $clog2(MAX_OUT + 1),
   localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [LINE_W-1:0] cfg_last,
   input  logic [ADDR_W-1:0] cfg_pitch,
   input  logic [FCW-1:0]    fifo_count,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BW-1:0]     req_beats,
   input  logic              rsp_valid,
   input  logic              rsp_last,
   output logic              frame_active,
   output logic              frame_done
);
   generate
      if (MAX_BURST > FIFO_DEPTH || MAX_BURST < 1 || MAX_OUT < 1 || LEN_W < BW)
      begin : g_bad_cfg
         $error("fsf_fetch_gen: burst must fit the FIFO and the length field");
      end
   endgenerate

   logic              busy, all_issued;
   logic [ADDR_W-1:0] line_addr;
   logic [LEN_W-1:0]  offset, remain;
   logic [LINE_W-1:0] line_idx;
   logic [FCW-1:0]    inflight;
   logic [OW-1:0]     outst;
   logic [BW-1:0]     blen;
   logic [FCW:0]      reserved;
   logic              credit_ok, fire, line_end, drained, abort, start;

   assign remain    = cfg_len - offset;
   assign blen      = (remain > LEN_W'(MAX_BURST)) ? BW'(MAX_BURST) : remain[BW-1:0];
   assign reserved  = {1'b0, fifo_count} + {1'b0, inflight};
   assign credit_ok = (32'(reserved) + 32'(blen)) <= 32'(FIFO_DEPTH);

   assign req_valid = busy && run && !all_issued && (outst < OW'(MAX_OUT)) && credit_ok;
   assign req_addr  = line_addr + ADDR_W'(offset);
   assign req_beats = blen;
   assign fire      = req_valid && req_ready;
   assign line_end  = (32'(offset) + 32'(blen)) >= 32'(cfg_len);

   assign drained      = (inflight == '0) && (outst == '0);
   assign frame_done   = busy && all_issued && drained;
   assign abort        = busy && !run && !all_issued && drained;
   assign start        = !busy && run;
   assign frame_active = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         all_issued <= 1'b0;
         line_addr  <= '0;
         offset     <= '0;
         line_idx   <= '0;
      end else if (start) begin
         busy       <= 1'b1;
         all_issued <= 1'b0;
         line_addr  <= cfg_base;      // start address is sampled only here
         offset     <= '0;
         line_idx   <= '0;
      end else if (frame_done || abort) begin
         busy <= 1'b0;
      end else if (fire) begin
         if (line_end) begin
            offset    <= '0;
            line_addr <= line_addr + cfg_pitch;
            if (line_idx == cfg_last) all_issued <= 1'b1;
            else                      line_idx   <= line_idx + LINE_W'(1);
         end else begin
            offset <= offset + LEN_W'(blen);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight <= '0;
         outst    <= '0;
      end else begin
         inflight <= inflight + (fire ? FCW'(blen) : FCW'(0)) - FCW'(rsp_valid);
         outst    <= outst + OW'(fire) - OW'(rsp_valid && rsp_last);
      end
   end

   p_beats_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_beats != '0) && (32'(req_beats) <= 32'(MAX_BURST)));
   p_within_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (32'(offset) + 32'(req_beats)) <= 32'(cfg_len));
   p_max_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(outst) <= 32'(MAX_OUT));
   p_rsp_expected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (inflight != '0));
   p_idle_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !req_valid);
endmodule

// File: rtl/fb_scan_fetch.sv
`timescale 1ns/1ps
module fb_scan_fetch #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINE_W     = 12,
   parameter int MAX_BURST  = 16,
   parameter int MAX_OUT    = 4,
   parameter int FIFO_DEPTH = 64,
   localparam int BEAT_W    = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [BEAT_W-1:0] rd_req_beats,
   input  logic              rd_rsp_valid,
   input  logic [7:0]        rd_rsp_data,
   input  logic              rd_rsp_last,
   output logic              px_valid,
   input  logic              px_ready,
   output logic [7:0]        px_data,
   output logic              frame_irq,
   output logic              underrun
);
   localparam int FCW = $clog2(FIFO_DEPTH + 1);

   logic [ADDR_W-1:0] cfg_base, cfg_pitch;
   logic [LEN_W-1:0]  cfg_len;
   logic [LINE_W-1:0] cfg_last;
   logic              run, frame_done, frame_active;
   logic [FCW-1:0]    fifo_count;
   logic              fifo_empty, fifo_full, pop;

   fsf_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .wr_addr    (reg_addr),
      .wr_data    (reg_wdata),
      .frame_done (frame_done),
      .base       (cfg_base),
      .line_len   (cfg_len),
      .last_line  (cfg_last),
      .pitch      (cfg_pitch),
      .run        (run),
      .irq        (frame_irq)
   );

   fsf_fetch_gen #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W),
      .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUT), .FIFO_DEPTH(FIFO_DEPTH)
   ) u_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .cfg_base     (cfg_base),
      .cfg_len      (cfg_len),
      .cfg_last     (cfg_last),
      .cfg_pitch    (cfg_pitch),
      .fifo_count   (fifo_count),
      .req_valid    (rd_req_valid),
      .req_ready    (rd_req_ready),
      .req_addr     (rd_req_addr),
      .req_beats    (rd_req_beats),
      .rsp_valid    (rd_rsp_valid),
      .rsp_last     (rd_rsp_last),
      .frame_active (frame_active),
      .frame_done   (frame_done)
   );

   fsf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rd_rsp_valid),
      .din   (rd_rsp_data),
      .pop   (pop),
      .dout  (px_data),
      .count (fifo_count),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign px_valid = !fifo_empty;
   assign pop      = px_valid && px_ready;
   assign underrun = frame_active && px_ready && fifo_empty;

   p_underrun_starved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> !px_valid && px_ready);
   p_full_blocks_nothing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !rd_rsp_valid || pop);
endmodule

// File: tb/fb_scan_fetch_tb.sv
`timescale 1ns/1ps
module fb_scan_fetch_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        rd_req_valid, rd_req_ready;
   logic [31:0] rd_req_addr;
   logic [4:0]  rd_req_beats;
   logic        rd_rsp_valid = 1'b0;
   logic [7:0]  rd_rsp_data = '0;
   logic        rd_rsp_last = 1'b0;
   logic        px_valid, px_ready;
   logic [7:0]  px_data;
   logic        frame_irq, underrun;

   always #5 clk = ~clk;

   fb_scan_fetch u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_last(rd_rsp_last),
      .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
      .frame_irq(frame_irq), .underrun(underrun)
   );

   int checks = 0, failures = 0, cyc = 0;
   int mem_lat = 4;
   bit mem_rdy = 1'b1;
   bit px_rdy_drv = 1'b0;
   assign rd_req_ready = mem_rdy;
   assign px_ready     = px_rdy_drv;

   always @(posedge clk) cyc++;

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // Memory model: in-order bursts, one byte per cycle after a fixed latency
   logic [31:0] q_addr [256];
   int          q_len  [256];
   int          q_due  [256];
   int          q_head = 0, q_tail = 0, beat = 0;
   logic [31:0] log_addr [512];
   int          log_beats[512];
   int          req_n = 0, out_cnt = 0, max_out = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         q_head = 0; q_tail = 0; beat = 0;
         req_n = 0; out_cnt = 0; max_out = 0;
         rd_rsp_valid = 1'b0; rd_rsp_last = 1'b0;
      end else begin
         if (q_head != q_tail && q_due[q_head % 256] <= cyc) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem_byte(q_addr[q_head % 256] + 32'(beat));
            rd_rsp_last  = (beat == q_len[q_head % 256] - 1);
            if (rd_rsp_last) begin
               beat = 0; q_head++; out_cnt--;
            end else beat++;
         end else begin
            rd_rsp_valid = 1'b0; rd_rsp_last = 1'b0;
         end
         if (rd_req_valid && rd_req_ready) begin
            q_addr[q_tail % 256] = rd_req_addr;
            q_len [q_tail % 256] = int'(rd_req_beats);
            q_due [q_tail % 256] = cyc + mem_lat;
            q_tail++;
            log_addr [req_n % 512] = rd_req_addr;
            log_beats[req_n % 512] = int'(rd_req_beats);
            req_n++; out_cnt++;
            if (out_cnt > max_out) max_out = out_cnt;
         end
      end
   end

   // Stream monitor
   logic [7:0] rx [2048];
   int rx_n = 0, ur_bad = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         rx_n = 0; ur_bad = 0;
      end else begin
         if (px_valid && px_ready) begin
            rx[rx_n % 2048] = px_data; rx_n++;
         end
         if (underrun && (!px_ready || px_valid)) ur_bad++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; px_rdy_drv = 1'b0; mem_rdy = 1'b1; reg_wr_en = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   task automatic cfg(input logic [31:0] b, input int len, input int last, input int pitch);
      wr(3'd0, b); wr(3'd1, 32'(len)); wr(3'd2, 32'(last)); wr(3'd3, 32'(pitch));
   endtask

   task automatic wait_rx(input int n);
      for (int k = 0; k < 6000 && rx_n < n; k++) @(posedge clk);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   // Compare rx[first .. first+n-1] against a frame at base/len/pitch
   task automatic cmp_frame(input string req, input int first, input int n,
                            input logic [31:0] b, input int len, input int pitch);
      int bad = 0, bad_at = -1;
      logic [7:0] e, first_exp = '0, first_act = '0;
      for (int k = 0; k < n; k++) begin
         e = mem_byte(b + 32'((k / len) * pitch + (k % len)));
         if (rx[(first + k) % 2048] !== e) begin
            if (bad == 0) begin bad_at = k; first_exp = e; first_act = rx[(first + k) % 2048]; end
            bad++;
         end
      end
      chk(bad == 0 && rx_n >= first + n, req, $sformatf("stream bytes (first bad %0d)", bad_at),
          longint'(first_act), longint'(first_exp));
   endtask

   task automatic t_reset();
      do_reset();
      wait_cycles(5);
      @(negedge clk);
      chk(px_valid == 1'b0,     "R1", "px_valid after reset", px_valid, 0);
      chk(rd_req_valid == 1'b0, "R1", "rd_req_valid after reset", rd_req_valid, 0);
      chk(frame_irq == 1'b0,    "R1", "frame_irq after reset", frame_irq, 0);
      chk(underrun == 1'b0,     "R1", "underrun after reset", underrun, 0);
      cfg(32'h100, 40, 2, 64);
      wait_cycles(10);
      chk(req_n == 0, "R1", "no request without run", req_n, 0);
   endtask

   task automatic t_stream();
      do_reset();
      mem_lat = 4; px_rdy_drv = 1'b1;
      cfg(32'h100, 40, 2, 64);
      wr(3'd4, 1);
      wait_rx(120);
      cmp_frame("R2", 0, 120, 32'h100, 40, 64);
      chk(log_beats[0] == 16 && log_beats[1] == 16 && log_beats[2] == 8, "R3",
          "bursts of a 40-byte line", log_beats[2], 8);
      chk(log_addr[1] == 32'h110 && log_addr[2] == 32'h120, "R3",
          "burst addresses within line", log_addr[2], 32'h120);
      chk(log_addr[3] == 32'h140 && log_beats[3] == 16, "R3",
          "second line starts at base+pitch", log_addr[3], 32'h140);
   endtask

   task automatic t_short();
      do_reset();
      mem_lat = 3; px_rdy_drv = 1'b1;
      cfg(32'h3000, 5, 3, 8);
      wr(3'd4, 1);
      wait_rx(20);
      cmp_frame("R2", 0, 20, 32'h3000, 5, 8);
      chk(log_beats[0] == 5, "R3", "short line single burst", log_beats[0], 5);
      chk(log_addr[1] == 32'h3008, "R3", "next short line address", log_addr[1], 32'h3008);
   endtask

   task automatic t_outstanding();
      do_reset();
      mem_lat = 40; px_rdy_drv = 1'b1;
      cfg(32'h0, 256, 3, 256);
      wr(3'd4, 1);
      wait_rx(200);
      chk(max_out == 4, "R4", "peak bursts in flight", max_out, 4);
      cmp_frame("R2", 0, 200, 32'h0, 256, 256);
   endtask

   task automatic t_backpressure();
      logic [7:0] lfsr = 8'hA5;
      do_reset();
      mem_lat = 3; px_rdy_drv = 1'b0;
      cfg(32'h40, 64, 3, 100);
      wr(3'd4, 1);
      wait_cycles(300);
      chk(rx_n == 0, "R5", "nothing delivered while stalled", rx_n, 0);
      chk(req_n == 4, "R5", "requests limited to FIFO room", req_n, 4);
      for (int k = 0; k < 4000 && rx_n < 256; k++) begin
         @(posedge clk); #1;
         px_rdy_drv = lfsr[0];
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      #1 px_rdy_drv = 1'b1;
      cmp_frame("R5", 0, 256, 32'h40, 64, 100);
      chk(ur_bad == 0, "R9", "underrun only when starved and ready", ur_bad, 0);
   endtask

   task automatic t_shadow();
      do_reset();
      mem_lat = 2; px_rdy_drv = 1'b1;
      cfg(32'h200, 16, 1, 32);
      wr(3'd4, 1);
      for (int k = 0; k < 100 && req_n < 1; k++) @(posedge clk);
      wr(3'd0, 32'h800);
      wait_rx(64);
      cmp_frame("R6", 0, 32, 32'h200, 16, 32);
      cmp_frame("R6", 32, 32, 32'h800, 16, 32);
   endtask

   task automatic t_irq();
      bit seen = 1'b0;
      do_reset();
      mem_lat = 6; px_rdy_drv = 1'b1;
      cfg(32'h10, 8, 0, 8);
      @(negedge clk);
      chk(frame_irq == 1'b0, "R7", "flag clear before run", frame_irq, 0);
      wr(3'd4, 1);
      for (int k = 0; k < 200 && !seen; k++) begin
         @(negedge clk);
         seen = frame_irq;
      end
      chk(seen, "R7", "flag sets at frame end", seen, 1);
      wr(3'd4, 0);
      wait_cycles(100);
      @(negedge clk);
      chk(frame_irq == 1'b1, "R7", "flag holds without clear", frame_irq, 1);
      wr(3'd5, 1);
      chk(frame_irq == 1'b0, "R7", "flag reads 0 after clear", frame_irq, 0);
      wait_cycles(50);
      @(negedge clk);
      chk(frame_irq == 1'b0, "R7", "flag stays clear while stopped", frame_irq, 0);
   endtask

   task automatic t_stop();
      int snap;
      do_reset();
      mem_lat = 10; px_rdy_drv = 1'b1;
      cfg(32'h0, 64, 31, 64);
      wr(3'd4, 1);
      for (int k = 0; k < 200 && req_n < 3; k++) @(posedge clk);
      wr(3'd4, 0);
      @(negedge clk);
      snap = req_n;
      wait_cycles(200);
      @(negedge clk);
      chk(req_n == snap, "R8", "no requests after stop", req_n, snap);
      chk(rd_req_valid == 1'b0, "R8", "request line idle after stop", rd_req_valid, 0);
      chk(frame_irq == 1'b0, "R8", "dropped frame raises no flag", frame_irq, 0);
      chk(underrun == 1'b0, "R9", "no underrun while idle", underrun, 0);
      wr(3'd4, 1);
      for (int k = 0; k < 50 && req_n <= snap; k++) @(posedge clk);
      chk(log_addr[snap % 512] == 32'h0, "R8", "restart at start address",
          log_addr[snap % 512], 0);
   endtask

   task automatic t_underrun();
      do_reset();
      mem_lat = 30; px_rdy_drv = 1'b1;
      cfg(32'h500, 16, 0, 16);
      wr(3'd4, 1);
      wait_cycles(15);
      @(negedge clk);
      chk(underrun == 1'b1, "R9", "underrun while waiting on memory", underrun, 1);
      wait_rx(16);
      cmp_frame("R9", 0, 16, 32'h500, 16, 16);
   endtask

   task automatic t_multi();
      do_reset();
      mem_lat = 2; px_rdy_drv = 1'b1;
      cfg(32'h60, 8, 1, 16);
      wr(3'd4, 1);
      wait_rx(48);
      cmp_frame("R10", 0, 16, 32'h60, 8, 16);
      cmp_frame("R10", 16, 16, 32'h60, 8, 16);
      cmp_frame("R10", 32, 16, 32'h60, 8, 16);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 150000);
      finish_run();
   end

   initial begin
      t_reset();
      t_stream();
      t_short();
      t_outstanding();
      t_backpressure();
      t_shadow();
      t_irq();
      t_stop();
      t_underrun();
      t_multi();
      finish_run();
   end
endmodule